// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block takes four peripheral transfer requests that arrive with no relation to the local clock and picks one channel to serve. Before it grants anything, it asks the host processor for the bus through a hold request. It then waits until the host confirms, with a hold acknowledge, that it has released the bus. Only then does it drive an acknowledge to the winning peripheral.

The winner is kept until the transfer engine signals end of service. A mode input chooses between two orders:

- Fixed order, where the lowest channel index always wins.
- Round-robin order, where the search starts at the channel after the one served last.

After end of service, the block asks for the next grant if another request is pending. If none is pending, it returns the bus to the host.

Top module: `dma_req_arbiter`

## Requirements
- R1: Each request input passes through a two-flop synchronizer. A request raised before a rising edge sets `hold_req_o` after the third rising edge, counting that one. It does not set it earlier.
- R2: `hold_req_o` is high whenever a synchronized request is pending or a channel is being served. It goes low one edge after end of service if no request is pending. It also goes low if all requests are withdrawn before `hold_ack_i` arrives.
- R3: Two rules govern `ack_o`:
  - At most one bit of `ack_o` is high at any time.
  - A bit of `ack_o` is high only while both `hold_ack_i` and `hold_req_o` are high. If `hold_ack_i` drops during service, `ack_o` clears at once and comes back when `hold_ack_i` returns.
- R4: With `rotate_i` = 0, the pending channel with the lowest index wins. Channel 0 is highest and channel 3 lowest. Bit n of `req_i` and `ack_o` belongs to channel n.
- R5: With `rotate_i` = 1, the search starts at the channel that follows the one served last, modulo 4, and takes the first pending channel. The served channel thereby becomes the lowest priority.
- R6: The winner is latched at the grant edge. It does not change before end of service, even if a higher-priority request appears or the served request is withdrawn.
- R7: If a request is still pending at end of service, `hold_req_o` stays high. The next channel is then granted one edge later while `hold_ack_i` is high.
- R8: Reset (`rst_ni` low, asynchronous) has three effects:
  - It clears `ack_o` and `hold_req_o`.
  - It abandons any service in progress.
  - It restores the start-of-search pointer to channel 0, so the first round-robin grant after reset goes to the lowest pending index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Peripheral requests, asynchronous, bit n = channel n |
| rotate_i | input | 1 | Priority mode: 0 fixed, 1 round-robin |
| hold_ack_i | input | 1 | Host has released the bus |
| done_i | input | 1 | End of service from the transfer engine |
| hold_req_o | output | 1 | Bus request to the host |
| ack_o | output | 4 | One-hot acknowledge to the served peripheral |

## Verification
End of service and a fresh arbitration can land in the same edge. When `done_i` arrives while another synchronized request is pending, the pointer update, the return to the hold phase and the next grant all follow one another with no idle gap.

The bench provokes this by keeping `hold_ack_i` high. It leaves a second request pending through the first service, pulses `done_i`, and then checks two things. First, `hold_req_o` has not dropped. Second, the next acknowledge appears exactly one edge later, on the channel the active order predicts.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SERVE = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int N_CH   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] async_i,
  output logic [N_CH-1:0] sync_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[c]};
    end
    assign sync_o[c] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pend_i,
  input  logic [CH_W-1:0] base_i,
  output logic            any_o,
  output logic [CH_W-1:0] idx_o,
  output logic [N_CH-1:0] oh_o
);
  // search from base_i upward with wrap; N_CH must be a power of two
  always_comb begin
    logic found;
    logic [CH_W-1:0] cand;
    found = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      cand = base_i + CH_W'(i);
      if (!found && pend_i[cand]) begin
        found = 1'b1;
        idx_o = cand;
      end
    end
    any_o = found;
    oh_o  = found ? (N_CH'(1) << idx_o) : '0;
  end

  AST_PICK_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_i) |-> ($onehot(oh_o) && ((oh_o & pend_i) != '0))); // R4
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic            rotate_i,
  input  logic            hold_ack_i,
  input  logic            done_i,
  output logic            hold_req_o,
  output logic [N_CH-1:0] ack_o
);
  import dma_arb_pkg::*;

  logic [N_CH-1:0] req_s;
  logic [N_CH-1:0] pick_oh;
  logic [CH_W-1:0] pick_idx, base_q, win_q, search_base;
  logic            pick_any;
  arb_state_e      state_q;

  dma_req_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (req_i),
    .sync_o  (req_s)
  );

  assign search_base = rotate_i ? base_q : '0;

  dma_prio_pick #(.N_CH(N_CH)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (req_s),
    .base_i (search_base),
    .any_o  (pick_any),
    .idx_o  (pick_idx),
    .oh_o   (pick_oh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (pick_any) state_q <= ST_HOLD;
        ST_HOLD: begin
          if (!pick_any) state_q <= ST_IDLE;
          else if (hold_ack_i) begin
            state_q <= ST_SERVE;
            win_q   <= pick_idx;
          end
        end
        ST_SERVE: begin
          if (done_i) begin
            base_q  <= win_q + CH_W'(1); // served channel drops to last
            state_q <= pick_any ? ST_HOLD : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_req_o = (state_q != ST_IDLE);
  assign ack_o = (state_q == ST_SERVE && hold_ack_i) ? (N_CH'(1) << win_q) : '0;

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)); // R3
  AST_ACK_NEEDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> (hold_ack_i && hold_req_o)); // R3
  AST_WINNER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SERVE && !done_i) |=> $stable(win_q)); // R6
  AST_HOLD_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SERVE && !done_i) |=> hold_req_o); // R2
  AST_RETURN_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SERVE && done_i && pick_any) |=> (hold_req_o && ack_o == '0)); // R7
endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       rot = 1'b0;
  logic       hack = 1'b0;
  logic       done = 1'b0;
  logic       hreq;
  logic [3:0] ack;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  dma_req_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rotate_i(rot),
    .hold_ack_i(hack), .done_i(done), .hold_req_o(hreq), .ack_o(ack)
  );

  // {rotate, req[3:0], expected ack[3:0]} served in order; pointer carries over
  localparam logic [8:0] VEC [10] = '{
    {1'b0, 4'b1111, 4'b0001},
    {1'b0, 4'b1010, 4'b0010},
    {1'b0, 4'b1000, 4'b1000},
    {1'b1, 4'b1111, 4'b0001},
    {1'b1, 4'b1111, 4'b0010},
    {1'b1, 4'b1001, 4'b1000},
    {1'b1, 4'b0110, 4'b0010},
    {1'b1, 4'b0011, 4'b0001},
    {1'b0, 4'b1100, 4'b0100},
    {1'b1, 4'b0101, 4'b0001}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_service();
    req = '0;
    step(3);
    done = 1'b1;
    step(1);
    done = 1'b0;
  endtask

  initial begin
    step(2);
    chk({3'b0, hreq}, 4'b0, "R8 reset hold_req");
    chk(ack, 4'b0, "R8 reset ack");
    rst_n = 1'b1;
    step(1);

    // R1 synchronizer latency
    req = 4'b0001;
    step(2);
    chk({3'b0, hreq}, 4'b0, "R1 hold_req not before third edge");
    step(1);
    chk({3'b0, hreq}, 4'b1, "R1 hold_req after third edge");
    req = '0;
    step(3);
    chk({3'b0, hreq}, 4'b0, "R2 withdrawn request drops hold_req");

    // table walk: R4 fixed, R5 rotating, R3 gating
    for (int v = 0; v < 10; v++) begin
      rot = VEC[v][8];
      req = VEC[v][7:4];
      step(3);
      chk({3'b0, hreq}, 4'b1, $sformatf("R2 vec%0d hold_req", v));
      step(2);
      chk(ack, 4'b0, $sformatf("R3 vec%0d no ack before hold_ack", v));
      hack = 1'b1;
      step(1);
      chk(ack, VEC[v][3:0], $sformatf("%s vec%0d winner", VEC[v][8] ? "R5" : "R4", v));
      finish_service();
      chk({3'b0, hreq}, 4'b0, $sformatf("R2 vec%0d hold_req after done", v));
      chk(ack, 4'b0, $sformatf("R2 vec%0d ack after done", v));
      hack = 1'b0;
      step(1);
    end

    // R6 latched winner, then R7 back-to-back grant
    rot = 1'b0;
    hack = 1'b1;
    req = 4'b0100;
    step(4);
    chk(ack, 4'b0100, "R6 initial grant");
    req = 4'b0101;
    step(4);
    chk(ack, 4'b0100, "R6 winner held against higher request");
    req = 4'b0001;
    step(3);
    done = 1'b1;
    step(1);
    done = 1'b0;
    chk({3'b0, hreq}, 4'b1, "R7 hold_req kept after done");
    chk(ack, 4'b0, "R7 no ack in the done edge");
    step(1);
    chk(ack, 4'b0001, "R7 next grant one edge later");
    finish_service();
    chk({3'b0, hreq}, 4'b0, "R2 idle after last service");

    // R3 hold_ack withdrawn mid-service
    req = 4'b0100;
    step(4);
    chk(ack, 4'b0100, "R3 grant");
    hack = 1'b0;
    #1;
    chk(ack, 4'b0, "R3 ack cleared when hold_ack drops");
    step(1);
    hack = 1'b1;
    #1;
    chk(ack, 4'b0100, "R3 ack returns with hold_ack");
    step(1);

    // R8 reset during service, pointer back to channel 0
    rst_n = 1'b0;
    #1;
    chk(ack, 4'b0, "R8 reset clears ack");
    chk({3'b0, hreq}, 4'b0, "R8 reset clears hold_req");
    req = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
    rot = 1'b1;
    req = 4'b1111;
    step(4);
    chk(ack, 4'b0001, "R8 rotating order restarts at channel 0");
    finish_service();
    hack = 1'b0;
    step(1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule